// File: doc/BRIEF.md
# Two-Wire EEPROM Page-Write Slave

This block is the write side of a serial EEPROM slave on a two-wire bus with a clock line and a data line. A fast system clock oversamples both lines. The block finds start and stop conditions and checks the device select byte against a fixed type code and three strap pins. It takes a 16-bit memory address and then gathers up to one row of data bytes in a row buffer. A write-control input decides whether those data bytes are acknowledged.

A stop placed in the first bit slot after an acknowledge commits the buffered bytes to a small internal byte array. The commit happens at the end of a self-timed busy period, and the bus side stays silent for that whole period. The array read port and the address pointer feed the read path that sits next to this block.

Top module: `eeprom_pw_slave`

## Requirements
- R1: After reset `busy_o` and `sda_pull_o` are 0, `addr_ptr_o` is 0 and every array byte reads 0.
- R2: A select byte is acknowledged (SDA pulled low in its ninth clock) only when bits 7..4 are 1010, bits 3..1 equal `chip_sel_i` and bit 0 (R/W) is 0. Any other select byte gets no acknowledge, and the slave ignores the bus until the next start.
- R3: After a matching select, both address bytes are acknowledged, high byte first. The array location is the address modulo `MEM_BYTES`.
- R4: The slave pulls SDA only in an acknowledge slot, and it starts pulling only while SCL is low.
- R5: If `wr_ctrl_i` is high at any sampled point from the start to the end of the second address byte, every data byte gets no acknowledge, `busy_o` stays 0 and the array is unchanged.
- R6: If `wr_ctrl_i` goes high only after the second address byte, the data bytes are still acknowledged and written.
- R7: A write cycle starts only for a stop that follows an acknowledged data byte, seen in the first bit slot of the next byte. A stop inside a byte, or a stop after the address bytes with no data byte, starts no write and changes nothing.
- R8: After each data byte only address bits 5..0 increment. Bytes past the end of the 64-byte row wrap to the start of that row, and later bytes overwrite earlier ones.
- R9: `busy_o` is high for exactly `WR_CYCLES` clocks per write cycle. The array keeps its old contents while `busy_o` is high and holds the new bytes once it falls.
- R10: While `busy_o` is high, `sda_pull_o` stays 0, even for the slave's own select code.
- R11: At the end of a write cycle `addr_ptr_o` = address bits 15..6 of the transfer, with bits 5..0 = (start offset + byte count) mod 64.
- R12: A start in the middle of a transfer discards all buffered bytes. Only bytes sent after the new start and before a valid stop are written.
- R13: Only row locations that received a byte are written. All other array bytes, including the rest of the row, keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock (oversamples the bus) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND) |
| chip_sel_i | input | 3 | Strap pins compared with select bits 3..1 |
| wr_ctrl_i | input | 1 | Write control; high blocks the write |
| mem_raddr_i | input | AW | Array read address for the read path |
| sda_pull_o | output | 1 | 1 pulls SDA low (acknowledge) |
| busy_o | output | 1 | Self-timed write cycle in progress |
| addr_ptr_o | output | 16 | Internal address pointer after the last write |
| mem_rdata_o | output | 8 | Array byte at `mem_raddr_i` (combinational) |

## Verification
Line changes reach the control logic three clocks later, after two synchronizer flops and one edge flop, and the acknowledge register updates one clock after that. The bench holds each bus phase for ten clocks and reads the acknowledge at the middle of the ninth SCL high phase, so every result has settled before it is sampled. `busy_o` rises about five clocks after the stop edge, and the bench samples it ten clocks after that edge. It counts busy clocks at each falling clock edge and compares the count with `WR_CYCLES` exactly. The array contents are checked once halfway through the busy period, where they must still be old, and again in a full sweep after `busy_o` falls.

// File: rtl/eeprom_pw_pkg.sv
package eeprom_pw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_AHI, ST_ALO, ST_DATA, ST_SKIP
  } bus_st_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/bus_cond_det.sv
module bus_cond_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wc_i,
  output logic scl_o,
  output logic sda_o,
  output logic wc_o,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic [1:0] scl_ff, sda_ff, wc_ff;
  logic       scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      wc_ff  <= 2'b00;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      wc_ff  <= {wc_ff[0], wc_i};
      scl_d  <= scl_ff[1];
      sda_d  <= sda_ff[1];
    end
  end

  assign scl_o      = scl_ff[1];
  assign sda_o      = sda_ff[1];
  assign wc_o       = wc_ff[1];
  assign start_o    = scl_ff[1] & scl_d & sda_d & ~sda_ff[1];
  assign stop_o     = scl_ff[1] & scl_d & ~sda_d & sda_ff[1];
  assign scl_rise_o = scl_ff[1] & ~scl_d;
  assign scl_fall_o = ~scl_ff[1] & scl_d;
endmodule

// File: rtl/rx_frame_ctl.sv
module rx_frame_ctl
  import eeprom_pw_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        hold_i,
  input  logic        scl_i,
  input  logic        sda_i,
  input  logic        wc_i,
  input  logic        start_i,
  input  logic        stop_i,
  input  logic        scl_rise_i,
  input  logic        scl_fall_i,
  input  logic [2:0]  chip_sel_i,
  output logic        pull_o,
  output logic        load_o,
  output logic        we_o,
  output logic        commit_o,
  output logic        discard_o,
  output logic        wc_seen_o,
  output logic [7:0]  data_o,
  output logic [15:0] addr_o,
  output bus_st_e     state_o
);
  bus_st_e    st_q;
  logic [3:0] bit_q;
  logic       in_ack_q, ack_q, pull_q, wc_q;
  logic [6:0] sh_q;
  logic [7:0] hi_q;
  logic [7:0] rx_byte;
  logic       byte_done, slot10;

  assign rx_byte   = {sh_q, sda_i};
  assign byte_done = scl_rise_i && (st_q != ST_IDLE) && !in_ack_q && (bit_q == 4'd7);
  // first bit slot after an acknowledged data byte
  assign slot10    = (st_q == ST_DATA) && (bit_q == 4'd1) && !in_ack_q && !wc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      bit_q     <= '0;
      in_ack_q  <= 1'b0;
      ack_q     <= 1'b0;
      pull_q    <= 1'b0;
      wc_q      <= 1'b0;
      sh_q      <= '0;
      hi_q      <= '0;
      load_o    <= 1'b0;
      we_o      <= 1'b0;
      commit_o  <= 1'b0;
      discard_o <= 1'b0;
      data_o    <= '0;
      addr_o    <= '0;
    end else begin
      load_o    <= 1'b0;
      we_o      <= 1'b0;
      commit_o  <= 1'b0;
      discard_o <= 1'b0;
      if (hold_i) begin
        st_q     <= ST_IDLE;
        bit_q    <= '0;
        in_ack_q <= 1'b0;
        pull_q   <= 1'b0;
      end else if (start_i) begin
        st_q      <= ST_DEV;
        bit_q     <= '0;
        in_ack_q  <= 1'b0;
        pull_q    <= 1'b0;
        wc_q      <= wc_i;
        discard_o <= 1'b1;
      end else if (stop_i) begin
        st_q      <= ST_IDLE;
        bit_q     <= '0;
        in_ack_q  <= 1'b0;
        pull_q    <= 1'b0;
        commit_o  <= slot10;
        discard_o <= !slot10;
      end else begin
        if (wc_i && (st_q inside {ST_DEV, ST_AHI, ST_ALO})) wc_q <= 1'b1;
        if (scl_rise_i && (st_q != ST_IDLE) && !in_ack_q && (bit_q < 4'd8)) begin
          sh_q  <= rx_byte[6:0];
          bit_q <= bit_q + 4'd1;
        end
        if (byte_done) begin
          unique case (st_q)
            ST_DEV: begin
              if (rx_byte[7:4] == DEV_TYPE && rx_byte[3:1] == chip_sel_i && !rx_byte[0]) begin
                ack_q <= 1'b1;
                st_q  <= ST_AHI;
              end else begin
                ack_q <= 1'b0;
                st_q  <= ST_SKIP;
              end
            end
            ST_AHI: begin
              hi_q  <= rx_byte;
              ack_q <= 1'b1;
              st_q  <= ST_ALO;
            end
            ST_ALO: begin
              addr_o <= {hi_q, rx_byte};
              load_o <= 1'b1;
              ack_q  <= 1'b1;
              st_q   <= ST_DATA;
            end
            ST_DATA: begin
              ack_q <= !wc_q;
              if (!wc_q) begin
                we_o   <= 1'b1;
                data_o <= rx_byte;
              end
            end
            default: ack_q <= 1'b0;
          endcase
        end
        if (scl_fall_i && (st_q != ST_IDLE)) begin
          if (in_ack_q) begin
            in_ack_q <= 1'b0;
            pull_q   <= 1'b0;
            bit_q    <= '0;
          end else if (bit_q == 4'd8) begin
            in_ack_q <= 1'b1;
            pull_q   <= ack_q;
          end
        end
      end
    end
  end

  assign pull_o    = pull_q;
  assign wc_seen_o = wc_q;
  assign state_o   = st_q;

  // R4
  ack_when_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pull_q && !$past(pull_q)) |-> !scl_i);
endmodule

// File: rtl/page_row_buf.sv
module page_row_buf #(
  parameter int PAGE_BYTES = 64,
  localparam int IW = $clog2(PAGE_BYTES)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic [15:0]             addr_i,
  input  logic                    we_i,
  input  logic [7:0]              data_i,
  input  logic                    clear_i,
  output logic [15:0]             base_o,
  output logic [IW-1:0]           idx_o,
  output logic [PAGE_BYTES-1:0]   valid_o,
  output logic [PAGE_BYTES*8-1:0] page_o
);
  logic [15:0]           base_q;
  logic [IW-1:0]         idx_q;
  logic [PAGE_BYTES-1:0] valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      idx_q   <= '0;
      valid_q <= '0;
    end else begin
      if (load_i) begin
        base_q <= addr_i;
        idx_q  <= addr_i[IW-1:0];
      end else if (we_i) begin
        idx_q <= idx_q + 1'b1;   // wraps inside the row
      end
      if (clear_i) valid_q <= '0;
      else if (we_i) valid_q[idx_q] <= 1'b1;
    end
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic [7:0] slot_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) slot_q <= '0;
      else if (we_i && idx_q == IW'(g)) slot_q <= data_i;
    end
    assign page_o[g*8 +: 8] = slot_q;
  end

  assign base_o  = base_q;
  assign idx_o   = idx_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/eeprom_pw_slave.sv
module eeprom_pw_slave
  import eeprom_pw_pkg::*;
#(
  parameter int MEM_BYTES  = 256,
  parameter int PAGE_BYTES = 64,
  parameter int WR_CYCLES  = 600,
  localparam int AW = $clog2(MEM_BYTES),
  localparam int IW = $clog2(PAGE_BYTES),
  localparam int CW = $clog2(WR_CYCLES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic [2:0]    chip_sel_i,
  input  logic          wr_ctrl_i,
  input  logic [AW-1:0] mem_raddr_i,
  output logic          sda_pull_o,
  output logic          busy_o,
  output logic [15:0]   addr_ptr_o,
  output logic [7:0]    mem_rdata_o
);
  logic scl_s, sda_s, wc_s, start_s, stop_s, rise_s, fall_s;
  logic pull, load, we, commit, discard, wc_seen;
  logic [7:0]  wdata;
  logic [15:0] laddr, base;
  logic [IW-1:0] idx;
  logic [PAGE_BYTES-1:0]   valid;
  logic [PAGE_BYTES*8-1:0] page;
  bus_st_e state;

  logic          busy_q, done;
  logic [CW-1:0] cnt_q;
  logic [15:0]   ptr_q;
  logic [7:0]    mem [MEM_BYTES];

  bus_cond_det u_det (
    .clk_i, .rst_ni, .scl_i, .sda_i, .wc_i(wr_ctrl_i),
    .scl_o(scl_s), .sda_o(sda_s), .wc_o(wc_s),
    .start_o(start_s), .stop_o(stop_s), .scl_rise_o(rise_s), .scl_fall_o(fall_s)
  );

  rx_frame_ctl u_ctl (
    .clk_i, .rst_ni, .hold_i(busy_q),
    .scl_i(scl_s), .sda_i(sda_s), .wc_i(wc_s),
    .start_i(start_s), .stop_i(stop_s), .scl_rise_i(rise_s), .scl_fall_i(fall_s),
    .chip_sel_i,
    .pull_o(pull), .load_o(load), .we_o(we), .commit_o(commit), .discard_o(discard),
    .wc_seen_o(wc_seen), .data_o(wdata), .addr_o(laddr), .state_o(state)
  );

  page_row_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk_i, .rst_ni,
    .load_i(load), .addr_i(laddr), .we_i(we), .data_i(wdata),
    .clear_i(discard | done),
    .base_o(base), .idx_o(idx), .valid_o(valid), .page_o(page)
  );

  assign done = busy_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      ptr_q  <= '0;
    end else if (busy_q) begin
      if (done) begin
        busy_q <= 1'b0;
        ptr_q  <= {base[15:IW], idx};
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end else if (commit && |valid) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(WR_CYCLES - 1);
    end
  end

  // array commit at the end of the timed cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= '0;
    end else if (done) begin
      for (int p = 0; p < PAGE_BYTES; p++)
        if (valid[p]) mem[{base[AW-1:IW], p[IW-1:0]}] <= page[p*8 +: 8];
    end
  end

  assign sda_pull_o  = pull;
  assign busy_o      = busy_q;
  assign addr_ptr_o  = ptr_q;
  assign mem_rdata_o = mem[mem_raddr_i];

  // R10
  silent_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !sda_pull_o);
  // R7
  commit_has_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> (|valid && $past(stop_s, 2)));
  // R5
  wc_blocks_buf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wc_seen && state == ST_DATA) |-> (valid == '0));
  // R9
  busy_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> $past(cnt_q) == '0);
endmodule

// File: tb/eeprom_pw_slave_test.sv
`timescale 1ns/1ps
module eeprom_pw_slave_test;
  localparam int WR = 600;
  localparam int Q  = 10;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, scl, m_sda, wr_ctrl, sda_pull, busy, sda_line;
  logic [2:0]  chip_sel;
  logic [7:0]  raddr, rdata;
  logic [15:0] ptr;

  assign sda_line = m_sda & ~sda_pull;

  eeprom_pw_slave #(.MEM_BYTES(256), .PAGE_BYTES(64), .WR_CYCLES(WR)) uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .chip_sel_i(chip_sel), .wr_ctrl_i(wr_ctrl), .mem_raddr_i(raddr),
    .sda_pull_o(sda_pull), .busy_o(busy), .addr_ptr_o(ptr), .mem_rdata_o(rdata)
  );

  int checks = 0, fails = 0;
  int busy_cyc = 0;
  bit pull_in_busy = 0;
  bit finished = 0;
  logic [7:0] shadow [256];
  logic [15:0] exp_ptr = 16'h0;

  always @(negedge clk) begin
    if (busy) busy_cyc++;
    if (busy && sda_pull) pull_in_busy = 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    m_sda = 1; wq(Q); scl = 1; wq(Q); m_sda = 0; wq(Q); scl = 0; wq(Q);
  endtask

  task automatic bus_stop;
    m_sda = 0; wq(Q); scl = 1; wq(Q); m_sda = 1; wq(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nb);
    for (int i = 7; i > 7 - nb; i--) begin
      m_sda = b[i]; wq(Q); scl = 1; wq(2*Q); scl = 0; wq(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    send_bits(b, 8);
    m_sda = 1; wq(Q); scl = 1; wq(Q);
    acked = (sda_line == 1'b0);
    wq(Q); scl = 0; wq(Q);
  endtask

  function automatic logic [7:0] dval(input int seed, input int i);
    return 8'((seed * 37 + i * 11 + 3) & 255);
  endfunction

  function automatic logic [7:0] sel(input logic [2:0] c, input bit rw);
    return {4'b1010, c, rw};
  endfunction

  // mode 0: wc low; 1: wc high throughout; 2: wc high for high address byte only; 3: wc high in data phase only
  task automatic page_write(input logic [15:0] a, input int n, input int seed, input int mode,
                            output int hdr_acks, output int data_acks);
    bit ak;
    hdr_acks = 0; data_acks = 0;
    wr_ctrl = (mode == 1);
    bus_start;
    send_byte(sel(chip_sel, 0), ak); hdr_acks += int'(ak);
    if (mode == 2) wr_ctrl = 1;
    send_byte(a[15:8], ak); hdr_acks += int'(ak);
    if (mode == 2) wr_ctrl = 0;
    send_byte(a[7:0], ak); hdr_acks += int'(ak);
    if (mode == 3) wr_ctrl = 1;
    for (int i = 0; i < n; i++) begin
      send_byte(dval(seed, i), ak); data_acks += int'(ak);
    end
    bus_stop;
    wr_ctrl = 0;
  endtask

  task automatic model_write(input logic [15:0] a, input int n, input int seed);
    logic [15:0] row;
    row = a & 16'hFFC0;
    for (int i = 0; i < n; i++)
      shadow[8'((row | 16'((a + 16'(i)) & 16'h3F)) & 16'hFF)] = dval(seed, i);
    exp_ptr = row | 16'((a + 16'(n)) & 16'h3F);
  endtask

  task automatic wait_idle;
    while (busy) @(negedge clk);
    wq(2);
  endtask

  task automatic read_mem(input logic [7:0] a, output logic [7:0] d);
    raddr = a; @(negedge clk); d = rdata;
  endtask

  task automatic compare_mem(input string tag);
    logic [7:0] d;
    for (int i = 0; i < 256; i++) begin
      read_mem(8'(i), d);
      chk(tag, d, shadow[i]);
    end
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary;
  end

  initial begin
    int ha, da;
    bit ak;
    logic [7:0] d;
    for (int i = 0; i < 256; i++) shadow[i] = 8'h00;
    rst_n = 0; scl = 1; m_sda = 1; wr_ctrl = 0; chip_sel = 3'b101; raddr = 0;
    wq(5); rst_n = 1; wq(5);

    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 pull", sda_pull, 0);
    chk("R1 ptr", ptr, 0);
    compare_mem("R1 mem");

    // R2 select sweep over strap codes and R/W
    for (int c = 0; c < 8; c++) begin
      for (int rw = 0; rw < 2; rw++) begin
        bus_start;
        send_byte(sel(3'(c), rw[0]), ak);
        chk($sformatf("R2 sel c=%0d rw=%0d", c, rw), ak, (c == 5 && rw == 0));
        bus_stop;
        chk("R7 no busy after select", busy, 0);
      end
    end
    bus_start; send_byte(8'b1011_101_0, ak); chk("R2 wrong type", ak, 0);
    send_byte(8'h00, ak); chk("R2 skip until start", ak, 0);
    bus_stop;

    // R3 R9 R11 byte write
    busy_cyc = 0;
    page_write(16'h1205, 1, 1, 0, ha, da);
    chk("R3 header acks", ha, 3);
    chk("R6 data ack", da, 1);
    chk("R9 busy after stop", busy, 1);
    wq(WR / 2);
    read_mem(8'h05, d); chk("R9 old data during busy", d, 8'h00);
    wait_idle;
    chk("R9 busy length", busy_cyc, WR);
    model_write(16'h1205, 1, 1);
    compare_mem("R3 byte write");
    chk("R11 ptr", ptr, exp_ptr);

    // R10 silence during busy
    pull_in_busy = 0;
    page_write(16'h0010, 3, 2, 0, ha, da);
    chk("R10 busy", busy, 1);
    bus_start; send_byte(sel(chip_sel, 0), ak); bus_stop;
    chk("R10 own select ignored", ak, 0);
    chk("R10 no pull during busy", pull_in_busy, 0);
    wait_idle;
    model_write(16'h0010, 3, 2);
    compare_mem("R13 three bytes");
    chk("R11 ptr3", ptr, exp_ptr);

    // R8 wrap inside row, several lengths and offsets
    page_write(16'h3478, 10, 3, 0, ha, da);
    chk("R8 acks10", da, 10);
    wait_idle; model_write(16'h3478, 10, 3);
    compare_mem("R8 wrap10"); chk("R11 ptr wrap", ptr, exp_ptr);
    page_write(16'h00C0, 66, 4, 0, ha, da);
    chk("R8 acks66", da, 66);
    wait_idle; model_write(16'h00C0, 66, 4);
    compare_mem("R8 overwrite"); chk("R11 ptr66", ptr, exp_ptr);
    page_write(16'h007F, 64, 5, 0, ha, da);
    wait_idle; model_write(16'h007F, 64, 5);
    compare_mem("R8 full row"); chk("R11 ptr64", ptr, exp_ptr);

    // R5 write control in header
    page_write(16'h0020, 4, 6, 1, ha, da);
    chk("R5 header still acked", ha, 3);
    chk("R5 data nack", da, 0);
    chk("R5 no busy", busy, 0);
    compare_mem("R5 unchanged");
    page_write(16'h0020, 4, 7, 2, ha, da);
    chk("R5 pulse data nack", da, 0);
    chk("R5 pulse no busy", busy, 0);
    compare_mem("R5 pulse unchanged");
    chk("R5 ptr kept", ptr, exp_ptr);

    // R6 write control only in data phase
    page_write(16'h0020, 4, 8, 3, ha, da);
    chk("R6 data acked", da, 4);
    wait_idle; model_write(16'h0020, 4, 8);
    compare_mem("R6 written");

    // R7 stop inside a byte
    bus_start;
    send_byte(sel(chip_sel, 0), ak); send_byte(8'h00, ak); send_byte(8'h30, ak);
    for (int i = 0; i < 3; i++) send_byte(8'hEE, ak);
    send_bits(8'h5A, 4);
    bus_stop;
    chk("R7 mid-byte stop no busy", busy, 0);
    compare_mem("R7 mid-byte unchanged");
    // R7 stop after address, no data
    page_write(16'h0031, 0, 9, 0, ha, da);
    chk("R7 no data no busy", busy, 0);

    // R12 repeated start discards buffered bytes
    bus_start;
    send_byte(sel(chip_sel, 0), ak); send_byte(8'h00, ak); send_byte(8'h48, ak);
    for (int i = 0; i < 3; i++) send_byte(8'hC3, ak);
    page_write(16'h0090, 1, 10, 0, ha, da);
    chk("R12 new transfer acked", ha, 3);
    wait_idle; model_write(16'h0090, 1, 10);
    compare_mem("R12 discard");
    chk("R11 ptr after restart", ptr, exp_ptr);

    summary;
  end
endmodule